// File: doc/BRIEF.md
# Ethernet Header Stack Classifier

This block watches a received Ethernet frame as a stream of 16-bit halfwords and works out, on the fly, which protocols it carries. It separates length-framed IEEE 802.3 frames from Ethernet II, steps over one 802.1Q tag, recognises the common network-layer EtherTypes, and for IPv4 and IPv6 goes on into the transport header to tell TCP, UDP and ICMP apart. The variable IPv4 and TCP header lengths are followed, so the block can mark the exact halfword where application payload begins. Nothing is buffered: each halfword is decoded in the cycle it arrives.

The input is a valid/ready stream. Each halfword carries two frame bytes in wire order, the earlier byte in bits 15:8. `in_sof` marks the first halfword of a frame, which is the start of the destination MAC address. The block never applies back-pressure: `in_ready` is always high, a halfword is consumed at every rising edge where `in_valid` is high, and cycles with `in_valid` low are idle and change nothing. The type flags build up while the header streams past. `hdr_done` reports that they are final, and `pl_start` flags the first payload halfword of a TCP or UDP frame in the same cycle that halfword is presented.

Top module: `frame_classifier`

## Requirements
- R1: `in_ready` is high at all times out of reset. One halfword is consumed per rising edge with `in_valid` high. Idle cycles (with `in_valid` low) anywhere in a frame do not change the result.
- R2: The halfword at index 6 is the type/length field. A value of 0x05DC or less sets flag bit 1 (802.3 framing). A larger value sets flag bit 0 (Ethernet II) and is decoded as an EtherType.
- R3: An EtherType of 0x8100 at index 6 sets flag bit 2 (tag). Index 7 is then skipped, and index 8 is read as the type/length field under the R2 rule. A second 0x8100 at index 8 is an unknown EtherType: it sets only bit 0 and ends the parse.
- R4: The EtherType sets one flag bit: 0x0806 sets bit 3, 0x8035 sets bit 4, 0x8137 sets bit 5, 0x0842 sets bit 6 (wake-up), 0x0800 sets bit 7 (IPv4) and 0x86DD sets bit 8 (IPv6). Any other value sets none of bits 3 to 8.
- R5: For 802.3 framing, the halfword after the length field is examined. A value of 0xFFFF or 0xE0E0 sets bit 5 (IPX). The header ends at that halfword.
- R6: For IPv4, bits 11:8 of the first IP halfword give the header length in 32-bit words, and values below 5 are taken as 5. The low byte of the fifth IP halfword is the protocol: 6 sets bit 9 (TCP), 17 sets bit 10 (UDP) and 1 sets bit 11 (ICMP).
- R7: For IPv6, the header is a fixed 40 bytes. The high byte of the fourth IP halfword is the next header: 6 sets bit 9, 17 sets bit 10 and 58 sets bit 11.
- R8: Bits 15:12 of the seventh TCP halfword give the TCP header length in 32-bit words, and values below 5 are taken as 5. The UDP header is fixed at 8 bytes.
- R9: `pl_start` is high, together with `in_valid`, while the first halfword after a TCP or UDP header is presented. It is high exactly once per such frame and never for any other class.
- R10: `hdr_done` rises in the cycle after the last halfword of the deepest parsed header is consumed. That header is the TCP or UDP header, otherwise the IP header, otherwise the link header. `hdr_done` and the flags then hold until the next start of frame.
- R11: A halfword accepted with `in_sof` high restarts the parse from any state. Flags and `hdr_done` are zero in the following cycle.
- R12: During and right after reset, the flags, `hdr_done` and `pl_start` are all zero.
- R13: Halfwords after the header is complete do not alter the flags, whatever they contain, until the next start of frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Halfword on `in_data` is valid |
| in_ready | output | 1 | Always high; block accepts every valid halfword |
| in_sof | input | 1 | Current halfword is the first of a frame |
| in_data | input | 16 | Frame halfword, earlier byte in bits 15:8 |
| flags | output | 12 | Type flags, bit meanings in R2 to R7 |
| hdr_done | output | 1 | Flags are final for the current frame |
| pl_start | output | 1 | Current halfword is the first payload halfword |

## Verification
IPv4 TCP frames are swept over every IP header length code and every TCP data offset code, with and without a tag. This separates offset arithmetic errors from clamping errors and from tag-skip errors, because each combination moves the payload strobe to a different computed index. The IPv4 protocol byte and the IPv6 next-header byte are each swept through all 256 values, which shows whether the transport decode is tied to the correct byte lane and to the correct IP version. A sweep of the type/length field across the 802.3 boundary, and across the named EtherTypes with several LLC words, separates length framing from type framing and the IPX cases from each other. A truncated frame followed by a new start of frame shows whether stale state is cleared. Payload halfwords carrying EtherType-like values show whether the block keeps decoding after the header ends.

// File: rtl/frame_cls_pkg.sv
package frame_cls_pkg;

  localparam int FLAG_W = 12;

  // flag bit positions
  localparam int F_ETH2 = 0;
  localparam int F_IEEE = 1;
  localparam int F_VLAN = 2;
  localparam int F_ARP  = 3;
  localparam int F_RARP = 4;
  localparam int F_IPX  = 5;
  localparam int F_WAKE = 6;
  localparam int F_IPV4 = 7;
  localparam int F_IPV6 = 8;
  localparam int F_TCP  = 9;
  localparam int F_UDP  = 10;
  localparam int F_ICMP = 11;

  // EtherType table; entry k drives flag bit F_ARP + k
  localparam int N_ET = 6;
  localparam logic [15:0] ET_CODE [N_ET] = '{
    16'h0806, 16'h8035, 16'h8137, 16'h0842, 16'h0800, 16'h86DD
  };
  localparam int ET_IDX_IP4 = F_IPV4 - F_ARP;
  localparam int ET_IDX_IP6 = F_IPV6 - F_ARP;

  localparam logic [15:0] ET_TAG       = 16'h8100;
  localparam logic [15:0] LLC_IPX_RAW  = 16'hFFFF;
  localparam logic [15:0] LLC_IPX_SAP  = 16'hE0E0;

  localparam logic [7:0] PR_ICMP   = 8'd1;
  localparam logic [7:0] PR_TCP    = 8'd6;
  localparam logic [7:0] PR_UDP    = 8'd17;
  localparam logic [7:0] PR_ICMPV6 = 8'd58;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ETH,
    ST_LLC,
    ST_IP4,
    ST_IP6,
    ST_TCP,
    ST_UDP,
    ST_PAY,
    ST_END
  } cls_state_t;

endpackage

// File: rtl/frame_cls_type_dec.sv
module frame_cls_type_dec
  import frame_cls_pkg::*;
#(
  parameter logic [15:0] LEN_MAX = 16'h05DC
) (
  input  logic [15:0]       etype,
  input  logic              tag_seen,
  output logic              is_len,
  output logic              is_tag,
  output logic              go_ip4,
  output logic              go_ip6,
  output logic [FLAG_W-1:0] l3_flags
);

  logic [N_ET-1:0] hit;

  assign is_len = (etype <= LEN_MAX);
  assign is_tag = !is_len && (etype == ET_TAG) && !tag_seen;

  for (genvar g = 0; g < N_ET; g++) begin : g_et
    assign hit[g] = !is_len && (etype == ET_CODE[g]);
  end

  assign go_ip4 = hit[ET_IDX_IP4];
  assign go_ip6 = hit[ET_IDX_IP6];

  always_comb begin
    l3_flags = '0;
    for (int k = 0; k < N_ET; k++) begin
      l3_flags[F_ARP + k] = hit[k];
    end
  end

endmodule

// File: rtl/frame_cls_l4_dec.sv
module frame_cls_l4_dec
  import frame_cls_pkg::*;
(
  input  logic [7:0] proto,
  input  logic       is_v6,
  output logic       is_tcp,
  output logic       is_udp,
  output logic       is_icmp
);

  assign is_tcp  = (proto == PR_TCP);
  assign is_udp  = (proto == PR_UDP);
  assign is_icmp = is_v6 ? (proto == PR_ICMPV6) : (proto == PR_ICMP);

endmodule

// File: rtl/frame_cls_hlen.sv
module frame_cls_hlen #(
  parameter int          CNT_W    = 6,
  parameter logic [3:0]  MIN_WORDS = 4'd5
) (
  input  logic [3:0]       words,
  output logic [CNT_W-1:0] last_idx
);

  logic [3:0] w_eff;

  assign w_eff    = (words < MIN_WORDS) ? MIN_WORDS : words;
  // 32-bit words to halfwords, minus one for the last index
  assign last_idx = CNT_W'({w_eff, 1'b0}) - CNT_W'(1);

endmodule

// File: rtl/frame_classifier.sv
module frame_classifier
  import frame_cls_pkg::*;
#(
  parameter logic [15:0] LEN_MAX       = 16'h05DC,
  parameter int          CNT_W         = 6,
  parameter int          IP6_HDR_BYTES = 40,
  parameter int          UDP_HDR_BYTES = 8,
  parameter logic [3:0]  HLEN_MIN      = 4'd5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sof,
  input  logic [15:0]       in_data,
  output logic [FLAG_W-1:0] flags,
  output logic              hdr_done,
  output logic              pl_start
);

  localparam int TYPE_IDX     = 6;
  localparam int TAG_HW       = 2;
  localparam int IP4_PROTO_HW = 4;
  localparam int IP6_NH_HW    = 3;
  localparam int TCP_DOFF_HW  = 6;
  localparam logic [CNT_W-1:0] LIM_MIN = CNT_W'(2 * int'(HLEN_MIN) - 1);
  localparam logic [CNT_W-1:0] LIM_IP6 = CNT_W'(IP6_HDR_BYTES / 2 - 1);
  localparam logic [CNT_W-1:0] LIM_UDP = CNT_W'(UDP_HDR_BYTES / 2 - 1);

  cls_state_t        st, st_n;
  logic [CNT_W-1:0]  rel, rel_n;
  logic [CNT_W-1:0]  lim, lim_n;
  logic              tag_seen, tag_n;
  logic [FLAG_W-1:0] flg, flg_n;
  logic              done_q, done_n;

  logic              td_len, td_tag, td_ip4, td_ip6;
  logic [FLAG_W-1:0] td_l3;
  logic              l4_tcp, l4_udp, l4_icmp;
  logic [7:0]        l4_proto;
  logic [CNT_W-1:0]  ihl_last, doff_last;
  logic [CNT_W-1:0]  type_pos;
  logic [CNT_W-1:0]  proto_pos;

  frame_cls_type_dec #(.LEN_MAX(LEN_MAX)) u_type (
    .etype    (in_data),
    .tag_seen (tag_seen),
    .is_len   (td_len),
    .is_tag   (td_tag),
    .go_ip4   (td_ip4),
    .go_ip6   (td_ip6),
    .l3_flags (td_l3)
  );

  assign l4_proto = (st == ST_IP6) ? in_data[15:8] : in_data[7:0];

  frame_cls_l4_dec u_l4 (
    .proto   (l4_proto),
    .is_v6   (st == ST_IP6),
    .is_tcp  (l4_tcp),
    .is_udp  (l4_udp),
    .is_icmp (l4_icmp)
  );

  frame_cls_hlen #(.CNT_W(CNT_W), .MIN_WORDS(HLEN_MIN)) u_ihl (
    .words    (in_data[11:8]),
    .last_idx (ihl_last)
  );

  frame_cls_hlen #(.CNT_W(CNT_W), .MIN_WORDS(HLEN_MIN)) u_doff (
    .words    (in_data[15:12]),
    .last_idx (doff_last)
  );

  assign type_pos  = tag_seen ? CNT_W'(TYPE_IDX + TAG_HW) : CNT_W'(TYPE_IDX);
  assign proto_pos = (st == ST_IP6) ? CNT_W'(IP6_NH_HW) : CNT_W'(IP4_PROTO_HW);

  always_comb begin
    st_n   = st;
    rel_n  = rel;
    lim_n  = lim;
    tag_n  = tag_seen;
    flg_n  = flg;
    done_n = done_q;
    if (in_valid) begin
      if (in_sof) begin
        st_n   = ST_ETH;
        rel_n  = CNT_W'(1);
        lim_n  = LIM_MIN;
        tag_n  = 1'b0;
        flg_n  = '0;
        done_n = 1'b0;
      end else begin
        case (st)
          ST_ETH: begin
            rel_n = rel + CNT_W'(1);
            if (rel == type_pos) begin
              if (td_len) begin
                flg_n[F_IEEE] = 1'b1;
                st_n          = ST_LLC;
              end else if (td_tag) begin
                flg_n[F_VLAN] = 1'b1;
                tag_n         = 1'b1;
              end else begin
                flg_n         = flg_n | td_l3;
                flg_n[F_ETH2] = 1'b1;
                rel_n         = '0;
                if (td_ip4) begin
                  st_n  = ST_IP4;
                  lim_n = LIM_MIN;
                end else if (td_ip6) begin
                  st_n  = ST_IP6;
                  lim_n = LIM_IP6;
                end else begin
                  st_n   = ST_END;
                  done_n = 1'b1;
                end
              end
            end
          end
          ST_LLC: begin
            if (in_data == LLC_IPX_RAW || in_data == LLC_IPX_SAP) begin
              flg_n[F_IPX] = 1'b1;
            end
            done_n = 1'b1;
            st_n   = ST_END;
          end
          ST_IP4, ST_IP6: begin
            rel_n = rel + CNT_W'(1);
            if (st == ST_IP4 && rel == '0) begin
              lim_n = ihl_last;
            end
            if (rel == proto_pos) begin
              flg_n[F_TCP]  = l4_tcp;
              flg_n[F_UDP]  = l4_udp;
              flg_n[F_ICMP] = l4_icmp;
            end
            if (rel == lim) begin
              rel_n = '0;
              if (flg[F_TCP]) begin
                st_n  = ST_TCP;
                lim_n = LIM_MIN;
              end else if (flg[F_UDP]) begin
                st_n  = ST_UDP;
                lim_n = LIM_UDP;
              end else begin
                st_n   = ST_END;
                done_n = 1'b1;
              end
            end
          end
          ST_TCP: begin
            rel_n = rel + CNT_W'(1);
            if (rel == CNT_W'(TCP_DOFF_HW)) begin
              lim_n = doff_last;
            end
            if (rel == lim) begin
              st_n   = ST_PAY;
              done_n = 1'b1;
            end
          end
          ST_UDP: begin
            rel_n = rel + CNT_W'(1);
            if (rel == lim) begin
              st_n   = ST_PAY;
              done_n = 1'b1;
            end
          end
          ST_PAY: begin
            st_n = ST_END;
          end
          default: begin
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      rel      <= '0;
      lim      <= '0;
      tag_seen <= 1'b0;
      flg      <= '0;
      done_q   <= 1'b0;
    end else begin
      st       <= st_n;
      rel      <= rel_n;
      lim      <= lim_n;
      tag_seen <= tag_n;
      flg      <= flg_n;
      done_q   <= done_n;
    end
  end

  assign in_ready = 1'b1;
  assign flags    = flg;
  assign hdr_done = done_q;
  assign pl_start = in_valid && !in_sof && (st == ST_PAY);

endmodule

// File: rtl/frame_classifier_sva.sv
module frame_classifier_sva
  import frame_cls_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_sof,
  input logic [FLAG_W-1:0] flags,
  input logic              hdr_done,
  input logic              pl_start
);

  assert_link_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags[F_IEEE:F_ETH2]));

  assert_l3_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags[F_IPV6:F_ARP]));

  assert_l4_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags[F_ICMP:F_TCP]));

  assert_l4_needs_ip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|flags[F_ICMP:F_TCP]) |-> (|flags[F_IPV6:F_IPV4]));

  assert_pl_context_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pl_start |-> (in_valid && hdr_done && (flags[F_TCP] || flags[F_UDP])));

  assert_pl_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pl_start |=> !pl_start);

  assert_done_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_done && !(in_valid && in_sof)) |=> (hdr_done && $stable(flags)));

  assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |=> (flags == '0 && !hdr_done));

endmodule

bind frame_classifier frame_classifier_sva u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_sof   (in_sof),
  .flags    (flags),
  .hdr_done (hdr_done),
  .pl_start (pl_start)
);

// File: tb/frame_classifier_test.sv
`timescale 1ns/1ps
module frame_classifier_test;

  localparam int B_ETH2 = 0, B_IEEE = 1, B_VLAN = 2, B_ARP = 3, B_RARP = 4,
                 B_IPX = 5, B_WAKE = 6, B_IP4 = 7, B_IP6 = 8, B_TCP = 9,
                 B_UDP = 10, B_ICMP = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_sof = 1'b0;
  logic [15:0] in_data = 16'h0;
  logic        in_ready;
  logic [11:0] flags;
  logic        hdr_done;
  logic        pl_start;

  int checks = 0;
  int errors = 0;
  int fcount = 0;

  logic [15:0] fr [0:127];
  int          flen;
  int          exp_pl;
  int          exp_done;
  logic [11:0] exp_flags;

  always #10 clk = ~clk;

  frame_classifier uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_sof   (in_sof),
    .in_data  (in_data),
    .flags    (flags),
    .hdr_done (hdr_done),
    .pl_start (pl_start)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic clr_frame();
    for (int i = 0; i < 128; i++) fr[i] = 16'h0000;
    for (int i = 0; i < 3; i++) fr[i] = 16'h0800;
    for (int i = 3; i < 6; i++) fr[i] = 16'h8100;
  endtask

  task automatic mk_l2(input int tag, input logic [15:0] et, output int l3);
    clr_frame();
    if (tag != 0) begin
      fr[6] = 16'h8100;
      fr[7] = 16'h0123;
      fr[8] = et;
      l3 = 9;
    end else begin
      fr[6] = et;
      l3 = 7;
    end
    exp_flags = 12'h0;
    if (tag != 0) exp_flags[B_VLAN] = 1'b1;
  endtask

  // transport part; kind 0 = TCP, 1 = UDP, 2 = other
  task automatic mk_l4(input int l4, input int kind, input int doff);
    int pay;
    int dc;
    dc = (doff < 5) ? 5 : doff;
    if (kind == 0) begin
      fr[l4 + 6] = {doff[3:0], 12'h018};
      pay = l4 + 2 * dc;
    end else if (kind == 1) begin
      pay = l4 + 4;
    end else begin
      pay = -1;
    end
    if (pay >= 0) begin
      fr[pay]     = 16'h0806;
      fr[pay + 1] = 16'h8100;
      exp_pl   = pay;
      exp_done = pay;
      flen     = pay + 2;
    end else begin
      fr[l4]     = 16'h86DD;
      fr[l4 + 1] = 16'h0806;
      exp_pl   = -1;
      exp_done = l4;
      flen     = l4 + 2;
    end
  endtask

  task automatic mk_ip4(input int tag, input int ihl, input int proto, input int doff);
    int l3;
    int ic;
    int kind;
    mk_l2(tag, 16'h0800, l3);
    ic = (ihl < 5) ? 5 : ihl;
    fr[l3]     = {4'h4, ihl[3:0], 8'h00};
    fr[l3 + 4] = {8'h40, proto[7:0]};
    exp_flags[B_ETH2] = 1'b1;
    exp_flags[B_IP4]  = 1'b1;
    kind = (proto == 6) ? 0 : (proto == 17) ? 1 : 2;
    if (proto == 6)  exp_flags[B_TCP]  = 1'b1;
    if (proto == 17) exp_flags[B_UDP]  = 1'b1;
    if (proto == 1)  exp_flags[B_ICMP] = 1'b1;
    mk_l4(l3 + 2 * ic, kind, doff);
  endtask

  task automatic mk_ip6(input int tag, input int nh);
    int l3;
    int kind;
    mk_l2(tag, 16'h86DD, l3);
    fr[l3]     = 16'h6000;
    fr[l3 + 3] = {nh[7:0], 8'h40};
    exp_flags[B_ETH2] = 1'b1;
    exp_flags[B_IP6]  = 1'b1;
    kind = (nh == 6) ? 0 : (nh == 17) ? 1 : 2;
    if (nh == 6)  exp_flags[B_TCP]  = 1'b1;
    if (nh == 17) exp_flags[B_UDP]  = 1'b1;
    if (nh == 58) exp_flags[B_ICMP] = 1'b1;
    mk_l4(l3 + 20, kind, 5);
  endtask

  // frames that stop at the link layer
  task automatic mk_simple(input int tag, input logic [15:0] et, input logic [15:0] llc);
    int l3;
    mk_l2(tag, et, l3);
    exp_pl = -1;
    if (et <= 16'h05DC) begin
      exp_flags[B_IEEE] = 1'b1;
      fr[l3] = llc;
      if (llc == 16'hFFFF || llc == 16'hE0E0) exp_flags[B_IPX] = 1'b1;
      exp_done = l3 + 1;
    end else begin
      exp_flags[B_ETH2] = 1'b1;
      case (et)
        16'h0806: exp_flags[B_ARP]  = 1'b1;
        16'h8035: exp_flags[B_RARP] = 1'b1;
        16'h8137: exp_flags[B_IPX]  = 1'b1;
        16'h0842: exp_flags[B_WAKE] = 1'b1;
        default: ;
      endcase
      fr[l3] = 16'h0800;
      exp_done = l3;
    end
    fr[exp_done]     = 16'h86DD;
    fr[exp_done + 1] = 16'h0806;
    flen = exp_done + 2;
  endtask

  task automatic run_frame(input bit do_chk, input string tag);
    int pl_idx = -1;
    int pl_cnt = 0;
    int dn_idx = -1;
    bit rdy_bad = 1'b0;
    for (int i = 0; i < flen; i++) begin
      if (((i + fcount) % 4) == 3) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_data  = fr[i];
      #5;
      if (!in_ready) rdy_bad = 1'b1;
      if (pl_start) begin
        pl_cnt++;
        if (pl_idx < 0) pl_idx = i;
      end
      if (i > 0 && hdr_done && dn_idx < 0) dn_idx = i;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
    #5;
    fcount++;
    if (do_chk) begin
      chk(flags == exp_flags, {tag, " R13 flags"}, int'(flags), int'(exp_flags));
      chk(hdr_done && dn_idx == exp_done, {tag, " R10 done index"}, dn_idx, exp_done);
      if (exp_pl < 0)
        chk(pl_cnt == 0, {tag, " R9 no strobe"}, pl_cnt, 0);
      else
        chk(pl_cnt == 1 && pl_idx == exp_pl, {tag, " R8 R9 strobe index"}, pl_idx, exp_pl);
      chk(!rdy_bad, {tag, " R1 ready"}, int'(rdy_bad), 0);
    end
  endtask

  initial begin
    #(20 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk);
    #5;
    chk(flags == 12'h0, "R12 flags in reset", int'(flags), 0);
    chk(!hdr_done && !pl_start, "R12 done/strobe in reset", int'({hdr_done, pl_start}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #5;
    chk(flags == 12'h0 && !hdr_done, "R12 after reset", int'(flags), 0);
    chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);

    // R2 R4 R5: type/length sweep around the boundary, without a tag
    for (int t = 16'h05D0; t <= 16'h05E0; t++) begin
      mk_simple(0, t[15:0], (t % 2 == 0) ? 16'hFFFF : 16'hAAAA);
      run_frame(1, "R2 R5 boundary");
    end

    // R3 R4 R5: named EtherTypes and LLC words, with and without a tag
    for (int tg = 0; tg < 2; tg++) begin
      for (int k = 0; k < 10; k++) begin
        logic [15:0] et;
        case (k)
          0: et = 16'h0806;
          1: et = 16'h8035;
          2: et = 16'h8137;
          3: et = 16'h0842;
          4: et = 16'h86DC;
          5: et = 16'h0600;
          6: et = 16'h05DC;
          7: et = 16'h0000;
          8: et = 16'h0801;
          default: et = (tg != 0) ? 16'h8100 : 16'hFFFF;
        endcase
        for (int l = 0; l < 3; l++) begin
          mk_simple(tg, et, (l == 0) ? 16'hFFFF : (l == 1) ? 16'hE0E0 : 16'hE0E1);
          run_frame(1, "R3 R4 R5 ethertype");
        end
      end
    end

    // R6 R8: every header length code and data offset code, TCP
    for (int tg = 0; tg < 2; tg++)
      for (int ihl = 0; ihl < 16; ihl++)
        for (int dof = 0; dof < 16; dof++) begin
          mk_ip4(tg, ihl, 6, dof);
          run_frame(1, "R6 R8 ipv4 tcp");
        end

    // R6: every protocol byte
    for (int tg = 0; tg < 2; tg++)
      for (int p = 0; p < 256; p++) begin
        mk_ip4(tg, p % 16, p, 5);
        run_frame(1, "R6 ipv4 proto");
      end

    // R7: every next-header byte
    for (int tg = 0; tg < 2; tg++)
      for (int p = 0; p < 256; p++) begin
        mk_ip6(tg, p);
        run_frame(1, "R7 ipv6 next header");
      end

    // R11: truncated TCP frame, then a new ARP frame
    mk_ip4(0, 7, 6, 9);
    flen = 14;
    run_frame(0, "R11 partial");
    chk(!hdr_done, "R11 partial not done", int'(hdr_done), 0);
    mk_simple(0, 16'h0806, 16'h0000);
    run_frame(1, "R11 restart");

    // R11: start of frame in the payload strobe position
    mk_ip4(1, 5, 17, 5);
    flen = exp_pl;
    run_frame(0, "R11 cut at payload");
    mk_ip6(0, 17);
    run_frame(1, "R11 restart udp");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule